// File: doc/BRIEF.md
# Integer ALU with Per-Operation Immediate Extension

This block is the combinational integer arithmetic and logic unit of a small RISC core. Each cycle it takes an operation code and two 32-bit register operands. An immediate-select flag can replace the second operand with a 16-bit immediate. The result is a single 32-bit word. Nothing in the block is registered, so the result follows its inputs within the same cycle.

The way the immediate is widened depends on the class of operation. Arithmetic operations sign-extend it. Bitwise logic and shift operations zero-extend it. A separate load-high operation always places the immediate in the upper half of the word, whatever the flag says.

Shift amounts come from the low five bits of the second operand. Addition and subtraction wrap modulo 2^32 and report no overflow. The block has no multiply, divide or flag outputs.

Top module: `int_alu`

## Requirements
- R1: With `op_code` = 0 (add), `result` equals `src_a` plus the second operand, modulo 2^32. When `imm_sel` = 1, the second operand is `imm16` sign-extended (bit 15 copied into bits 31..16).
- R2: With `op_code` = 1 (subtract), `result` equals `src_a` minus the second operand, modulo 2^32. When `imm_sel` = 1, the second operand is `imm16` sign-extended.
- R3: With `op_code` = 2, 3 or 4 (AND, OR, XOR), `result` is the bitwise AND, OR or XOR of `src_a` and the second operand. When `imm_sel` = 1, the second operand is `imm16` zero-extended.
- R4: With `op_code` = 5 (XNOR), `result` is the bitwise complement of `src_a` XOR the second operand. When `imm_sel` = 1, the second operand is `imm16` zero-extended.
- R5: With `op_code` = 6 (shift left), `result` is `src_a` shifted left, with zeros entering at bit 0. The shift amount is bits 4..0 of the second operand, and a shift of 0 returns `src_a` unchanged. When `imm_sel` = 1, the second operand is `imm16` zero-extended.
- R6: With `op_code` = 7 (logical shift right), `result` is `src_a` shifted right by bits 4..0 of the second operand, with zeros entering at bit 31.
- R7: With `op_code` = 8 (arithmetic shift right), `result` is `src_a` shifted right by bits 4..0 of the second operand, with copies of `src_a[31]` entering at bit 31.
- R8: With `op_code` = 9 (load high), `result[31:16]` equals `imm16` and `result[15:0]` is zero. `src_a`, `src_b` and `imm_sel` have no effect on the result.
- R9: When `imm_sel` = 0, `imm16` has no effect for `op_code` values 0 through 8. The second operand is then `src_b`.
- R10: For `op_code` values 10 through 15, `result` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 4 | Operation selector; encodings listed in the requirements |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| imm16 | input | 16 | Immediate value |
| imm_sel | input | 1 | 1 selects the widened immediate as the second operand |
| result | output | 32 | Operation result |

## Verification
Immediate assertions run whenever the inputs change. They check the following:
- the inverse relations of add and subtract;
- that XNOR complements XOR;
- the halves of a load-high result;
- the vacated top bit of each right shift;
- the zero result of unused codes.

None of the assertions can tell sign extension from zero extension of the immediate, or check every shifted bit position. The bench's reference model shows these by exhaustive sweeps over corner operands and immediates and by random stimulus. The bench also shows that the immediate is ignored when `imm_sel` is clear.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int OP_W   = 4
) (
  input  logic [OP_W-1:0]   op_code,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm16,
  input  logic              imm_sel,
  output logic [DATA_W-1:0] result
);

  localparam int SH_W = $clog2(DATA_W);

  localparam logic [OP_W-1:0] OP_ADD  = OP_W'(0);
  localparam logic [OP_W-1:0] OP_SUB  = OP_W'(1);
  localparam logic [OP_W-1:0] OP_AND  = OP_W'(2);
  localparam logic [OP_W-1:0] OP_OR   = OP_W'(3);
  localparam logic [OP_W-1:0] OP_XOR  = OP_W'(4);
  localparam logic [OP_W-1:0] OP_XNOR = OP_W'(5);
  localparam logic [OP_W-1:0] OP_SLL  = OP_W'(6);
  localparam logic [OP_W-1:0] OP_SRL  = OP_W'(7);
  localparam logic [OP_W-1:0] OP_SRA  = OP_W'(8);
  localparam logic [OP_W-1:0] OP_LDHI = OP_W'(9);

  logic              arith_cls;
  logic [DATA_W-1:0] imm_wide;
  logic [DATA_W-1:0] opnd_b;
  logic [SH_W-1:0]   shamt;

  assign arith_cls = (op_code == OP_ADD) || (op_code == OP_SUB);
  assign imm_wide  = arith_cls ? {{(DATA_W-IMM_W){imm16[IMM_W-1]}}, imm16}
                               : {{(DATA_W-IMM_W){1'b0}}, imm16};
  assign opnd_b    = imm_sel ? imm_wide : src_b;
  assign shamt     = opnd_b[SH_W-1:0];

  always_comb begin
    case (op_code)
      OP_ADD:  result = src_a + opnd_b;
      OP_SUB:  result = src_a - opnd_b;
      OP_AND:  result = src_a & opnd_b;
      OP_OR:   result = src_a | opnd_b;
      OP_XOR:  result = src_a ^ opnd_b;
      OP_XNOR: result = ~(src_a ^ opnd_b);
      OP_SLL:  result = src_a << shamt;
      OP_SRL:  result = src_a >> shamt;
      OP_SRA:  result = DATA_W'($signed(src_a) >>> shamt);
      OP_LDHI: result = {imm16, {(DATA_W-IMM_W){1'b0}}};
      default: result = '0;
    endcase
  end

  always_comb begin
    // R1
    if (op_code == OP_ADD)
      add_inverse_chk: assert (DATA_W'(result - opnd_b) == src_a);
    // R2
    if (op_code == OP_SUB)
      sub_inverse_chk: assert (DATA_W'(result + opnd_b) == src_a);
    // R4
    if (op_code == OP_XNOR)
      xnor_compl_chk: assert ((result ^ src_a ^ opnd_b) == {DATA_W{1'b1}});
    // R6
    if (op_code == OP_SRL && shamt != '0)
      srl_zero_fill_chk: assert (result[DATA_W-1] == 1'b0);
    // R7
    if (op_code == OP_SRA)
      sra_sign_keep_chk: assert (result[DATA_W-1] == src_a[DATA_W-1]);
    // R8
    if (op_code == OP_LDHI)
      ldhi_halves_chk: assert (result[DATA_W-IMM_W-1:0] == '0 &&
                               result[DATA_W-1:DATA_W-IMM_W] == imm16);
    // R10
    if (op_code > OP_LDHI)
      unused_zero_chk: assert (result == '0);
  end

endmodule

// File: tb/int_alu_test.sv
module int_alu_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_code = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [15:0] imm16 = '0;
  logic        imm_sel = 1'b0;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  int_alu uut (
    .op_code(op_code), .src_a(src_a), .src_b(src_b),
    .imm16(imm16), .imm_sel(imm_sel), .result(result)
  );

  function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [15:0] im,
                                        input logic sel);
    logic [31:0] sx, zx, bb, r;
    int n;
    sx = 32'($signed(im));
    zx = 32'(im);
    if (!sel) bb = b;
    else if (op < 4'd2) bb = sx;
    else bb = zx;
    n = int'(bb % 32);
    r = a;
    case (op)
      4'd0: r = 32'(longint'(a) + longint'(bb));
      4'd1: r = 32'(longint'(a) - longint'(bb) + 64'h1_0000_0000);
      4'd2: for (int i = 0; i < 32; i++) r[i] = a[i] && bb[i];
      4'd3: for (int i = 0; i < 32; i++) r[i] = a[i] || bb[i];
      4'd4: for (int i = 0; i < 32; i++) r[i] = a[i] != bb[i];
      4'd5: for (int i = 0; i < 32; i++) r[i] = a[i] == bb[i];
      4'd6: repeat (n) r = {r[30:0], 1'b0};
      4'd7: repeat (n) r = {1'b0, r[31:1]};
      4'd8: repeat (n) r = {r[31], r[31:1]};
      4'd9: r = im * 32'h10000;
      default: r = 32'h0;
    endcase
    return r;
  endfunction

  function automatic string tag(input logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3, 4'd4: return "R3";
      4'd5: return "R4";
      4'd6: return "R5";
      4'd7: return "R6";
      4'd8: return "R7";
      4'd9: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] exp);
    checks++;
    if (result !== exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h imm=%h sel=%0b actual=%h expected=%h",
               req, op_code, src_a, src_b, imm16, imm_sel, result, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic sel, input string req);
    @(negedge clk);
    op_code = op; src_a = a; src_b = b; imm16 = im; imm_sel = sel;
    @(posedge clk);
    #2;
    check(req, model(op, a, b, im, sel));
  endtask

  logic [31:0] corner [4] = '{32'h0, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF};
  logic [15:0] icorn  [4] = '{16'h0, 16'h7FFF, 16'h8000, 16'hFFFF};

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1", 32'h0);
    rst_n = 1'b1;

    apply(4'd0, 32'h0000_0010, 32'h0, 16'hFFFF, 1'b1, "R1");
    check("R1", 32'h0000_000F);
    apply(4'd1, 32'h0, 32'h0, 16'h8000, 1'b1, "R2");
    check("R2", 32'h0000_8000);
    apply(4'd2, 32'hFFFF_FFFF, 32'h0, 16'h8001, 1'b1, "R3");
    check("R3", 32'h0000_8001);
    apply(4'd5, 32'h0, 32'h0, 16'hFFFF, 1'b1, "R4");
    check("R4", 32'hFFFF_0000);
    apply(4'd6, 32'h1, 32'h0, 16'hFFE1, 1'b1, "R5");
    check("R5", 32'h0000_0002);
    apply(4'd6, 32'h1234_5678, 32'h20, 16'h0, 1'b0, "R5");
    check("R5", 32'h1234_5678);
    apply(4'd7, 32'h8000_0000, 32'd31, 16'h0, 1'b0, "R6");
    check("R6", 32'h0000_0001);
    apply(4'd8, 32'h8000_0000, 32'd31, 16'h0, 1'b0, "R7");
    check("R7", 32'hFFFF_FFFF);
    apply(4'd9, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 16'hA5C3, 1'b0, "R8");
    check("R8", 32'hA5C3_0000);
    apply(4'd9, 32'h0, 32'h0, 16'hA5C3, 1'b1, "R8");
    check("R8", 32'hA5C3_0000);
    apply(4'd0, 32'h5, 32'h3, 16'hFFFF, 1'b0, "R9");
    check("R9", 32'h8);
    apply(4'd3, 32'h0, 32'h0, 16'h1234, 1'b0, "R9");
    check("R9", 32'h0);
    apply(4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 1'b1, "R10");
    check("R10", 32'h0);

    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          for (int s = 0; s < 2; s++)
            apply(4'(op), corner[i], corner[j], icorn[j], 1'(s), tag(4'(op)));

    for (int k = 0; k < 2000; k++) begin
      logic [3:0] rop;
      rop = 4'($urandom_range(0, 15));
      apply(rop, $urandom, $urandom, 16'($urandom), 1'($urandom), tag(rop));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule